// File: doc/BRIEF.md
# Word-Clock Sync-Loss Mute Controller

This block sits beside the sample paths of an audio converter. It decides when converted samples may pass to the rest of the system. A free-running system clock runs at a fixed multiple of the sample rate, and the block samples the bit clock and the left/right word clock on it. At each rising edge of the word clock it measures the phase of that edge within the sample frame. It tolerates any fixed phase. If the edge moves between frames by more than a threshold given in bit-clock periods, it declares the link out of step. It then holds both the record-side (ADC) and playback-side (DAC) sample outputs at bipolar zero, which is all-zero in two's complement.

Lock is regained when two consecutive word-clock edges agree within the threshold. After that, each path stays at zero for its own number of further frames before samples pass again. Reset and power-down have longer hold-off counts, and those also start once lock is held. Separately, a zero-run detector watches the serial input data. After a long unbroken run of zero bits it asserts an enable that pulls an open-drain flag pin low.

Top module: `audio_sync_mute`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `adc_muted` and `dac_muted` are 1, `adc_out` and `dac_out` are 0, and `zflag_oe` is 0.
- R2: A muted path drives an all-zero output word. An unmuted path drives its input word one clock later.
- R3: Lock is taken at the second of two consecutive word-clock rising edges whose phases modulo `FRAME_CLKS` are no more than `LOSS_BCKS*BCK_CLKS` system clocks apart, whatever the absolute phase.
- R4: After reset, call the first word-clock rising edge edge 0. The ADC path unmutes from edge `1+ADC_PWR_FRAMES` onward and the DAC path from edge `1+DAC_PWR_FRAMES` onward, provided every edge stays in step.
- R5: An edge that moves by up to `LOSS_BCKS*BCK_CLKS` system clocks (24 with the defaults), early or late, keeps lock and leaves both paths unmuted.
- R6: An edge that is earlier or later by more than the threshold causes loss of lock. An absent edge has the same effect. Both outputs are zero before the middle of the next frame.
- R7: After loss, call the first edge of the new phase edge 0. ADC unmutes from edge `1+ADC_RESYNC_FRAMES` and DAC from edge `1+DAC_RESYNC_FRAMES`.
- R8: While `pwr_dn` is high, both paths are muted and the phase reference is cleared. After release, the timing of R4 applies again.
- R9: `zflag_oe` goes to 1 once `ZERO_RUN_BCKS` consecutive bit-clock rising edges have sampled `sdin` = 0. It stays at 1 while zeros continue.
- R10: Any bit-clock rising edge that samples `sdin` = 1 clears `zflag_oe` and restarts the zero count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `FRAME_CLKS` cycles per sample frame |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down request, active high |
| bck | input | 1 | Bit clock, sampled on `clk` |
| lrck | input | 1 | Word clock, sampled on `clk` |
| sdin | input | 1 | Serial input data bit, sampled at bit-clock rise |
| adc_in | input | DATA_W | Record-path sample word |
| dac_in | input | DATA_W | Playback-path sample word |
| adc_out | output | DATA_W | Record-path word, zero while muted |
| dac_out | output | DATA_W | Playback-path word, zero while muted |
| adc_muted | output | 1 | Record path held at zero |
| dac_muted | output | 1 | Playback path held at zero |
| zflag_oe | output | 1 | Drive the open-drain zero flag low |

## Verification
The bench sweeps edge shifts on both sides of the threshold: ±20, ±24, ±25 and ±28 system clocks. A comparison off by one, or one that only measures late edges, either mutes at 24 or keeps passing samples at 25. An edge that never arrives must also cause loss, so a design that only acts on edges it sees would pass stale data. Release is checked frame by frame after reset, power-down and loss, from several starting phases, so a hold-off counter that is off by one frame, or that counts before lock, unmutes a frame early or late. The zero-run count is checked after every single bit-clock pulse around its terminal value, which exposes an early flag, a flag that fails to saturate, or a count that survives a one bit.

// File: rtl/audio_sync_pkg.sv
package audio_sync_pkg;

    typedef enum logic {
        TRK_ACQUIRE = 1'b0,
        TRK_LOCKED  = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic locked;
        logic step;
        logic loss;
    } trk_evt_t;

    function automatic int unsigned phase_dist(int unsigned a, int unsigned b, int unsigned frame);
        int unsigned d;
        d = (a >= b) ? (a - b) : (a + frame - b);
        return (d > frame - d) ? (frame - d) : d;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sync_phase_tracker.sv
module sync_phase_tracker
    import audio_sync_pkg::*;
#(
    parameter int unsigned FRAME_CLKS  = 256,
    parameter int unsigned THRESH_CLKS = 24
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     lrck,
    output trk_evt_t evt
);
    localparam int unsigned PH_W    = $clog2(FRAME_CLKS);
    localparam int unsigned TIMEOUT = FRAME_CLKS + THRESH_CLKS;
    localparam int unsigned TO_W    = $clog2(TIMEOUT + 1);

    logic            lrck_q, lrck_q2;
    logic [PH_W-1:0] phase_cnt;
    logic [PH_W-1:0] ref_ph;
    logic            have_cand;
    trk_state_e      state;
    logic [TO_W-1:0] since;
    logic            step_q, loss_q;
    logic            edge_seen;
    logic            near;

    assign edge_seen = lrck_q & ~lrck_q2;
    assign near      = phase_dist(32'(phase_cnt), 32'(ref_ph), FRAME_CLKS) <= THRESH_CLKS;

    always_ff @(posedge clk) begin
        if (clr) begin
            lrck_q    <= 1'b1;
            lrck_q2   <= 1'b1;
            phase_cnt <= '0;
        end else begin
            lrck_q    <= lrck;
            lrck_q2   <= lrck_q;
            phase_cnt <= (phase_cnt == PH_W'(FRAME_CLKS - 1)) ? '0 : phase_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state     <= TRK_ACQUIRE;
            ref_ph    <= '0;
            have_cand <= 1'b0;
            since     <= '0;
            step_q    <= 1'b0;
            loss_q    <= 1'b0;
        end else begin
            step_q <= 1'b0;
            loss_q <= 1'b0;
            if (edge_seen)
                since <= '0;
            else if (since != TO_W'(TIMEOUT))
                since <= since + 1'b1;

            if (edge_seen) begin
                ref_ph    <= phase_cnt;
                have_cand <= 1'b1;
                if (state == TRK_ACQUIRE) begin
                    if (have_cand && near)
                        state <= TRK_LOCKED;
                end else if (near) begin
                    step_q <= 1'b1;
                end else begin
                    state  <= TRK_ACQUIRE;
                    loss_q <= 1'b1;
                end
            end else if (since == TO_W'(TIMEOUT)) begin
                have_cand <= 1'b0;
                if (state == TRK_LOCKED) begin
                    state  <= TRK_ACQUIRE;
                    loss_q <= 1'b1;
                end
            end
        end
    end

    assign evt.locked = (state == TRK_LOCKED);
    assign evt.step   = step_q;
    assign evt.loss   = loss_q;

endmodule

// File: rtl/release_timer.sv
module release_timer
    import audio_sync_pkg::*;
#(
    parameter int unsigned PWR_FRAMES = 18436,
    parameter int unsigned RSY_FRAMES = 32
) (
    input  logic     clk,
    input  logic     clr,
    input  trk_evt_t evt,
    output logic     mute
);
    localparam int unsigned MAXV = max_u(PWR_FRAMES, RSY_FRAMES);
    localparam int unsigned CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= CW'(PWR_FRAMES);
        else if (evt.loss) begin
            if (cnt < CW'(RSY_FRAMES))
                cnt <= CW'(RSY_FRAMES);
        end else if (evt.step && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign mute = !evt.locked || (cnt != '0);

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
    parameter int unsigned RUN_BCKS = 65536
) (
    input  logic clk,
    input  logic clr,
    input  logic bck,
    input  logic sdin,
    output logic flag
);
    localparam int unsigned CW = $clog2(RUN_BCKS + 1);

    logic          bck_q, bck_q2, sd_q;
    logic [CW-1:0] run_cnt;
    logic          rise;

    assign rise = bck_q & ~bck_q2;

    always_ff @(posedge clk) begin
        if (clr) begin
            bck_q   <= 1'b1;
            bck_q2  <= 1'b1;
            sd_q    <= 1'b0;
            run_cnt <= '0;
        end else begin
            bck_q  <= bck;
            bck_q2 <= bck_q;
            sd_q   <= sdin;
            if (rise) begin
                if (sd_q)
                    run_cnt <= '0;
                else if (run_cnt != CW'(RUN_BCKS))
                    run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign flag = (run_cnt == CW'(RUN_BCKS));

endmodule

// File: rtl/audio_sync_mute.sv
module audio_sync_mute
    import audio_sync_pkg::*;
#(
    parameter int unsigned DATA_W            = 20,
    parameter int unsigned FRAME_CLKS        = 256,
    parameter int unsigned BCK_CLKS          = 4,
    parameter int unsigned LOSS_BCKS         = 6,
    parameter int unsigned ADC_PWR_FRAMES    = 18436,
    parameter int unsigned DAC_PWR_FRAMES    = 16384,
    parameter int unsigned ADC_RESYNC_FRAMES = 32,
    parameter int unsigned DAC_RESYNC_FRAMES = 32,
    parameter int unsigned ZERO_RUN_BCKS     = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              bck,
    input  logic              lrck,
    input  logic              sdin,
    input  logic [DATA_W-1:0] adc_in,
    input  logic [DATA_W-1:0] dac_in,
    output logic [DATA_W-1:0] adc_out,
    output logic [DATA_W-1:0] dac_out,
    output logic              adc_muted,
    output logic              dac_muted,
    output logic              zflag_oe
);
    localparam int unsigned THRESH_CLKS = LOSS_BCKS * BCK_CLKS;
    localparam int unsigned NPATH       = 2;

    logic                         clr;
    trk_evt_t                     trk_evt;
    logic [NPATH-1:0]             mute_c;
    logic [NPATH-1:0]             mute_q;
    logic [NPATH-1:0][DATA_W-1:0] din_v;
    logic [NPATH-1:0][DATA_W-1:0] dout_q;

    assign clr      = rst | pwr_dn;
    assign din_v[0] = adc_in;
    assign din_v[1] = dac_in;

    sync_phase_tracker #(
        .FRAME_CLKS (FRAME_CLKS),
        .THRESH_CLKS(THRESH_CLKS)
    ) u_trk (
        .clk (clk),
        .clr (clr),
        .lrck(lrck),
        .evt (trk_evt)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        release_timer #(
            .PWR_FRAMES((p == 0) ? ADC_PWR_FRAMES : DAC_PWR_FRAMES),
            .RSY_FRAMES((p == 0) ? ADC_RESYNC_FRAMES : DAC_RESYNC_FRAMES)
        ) u_tmr (
            .clk (clk),
            .clr (clr),
            .evt (trk_evt),
            .mute(mute_c[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mute_q <= '1;
            dout_q <= '0;
        end else begin
            for (int p = 0; p < NPATH; p++) begin
                mute_q[p] <= mute_c[p];
                dout_q[p] <= mute_c[p] ? '0 : din_v[p];
            end
        end
    end

    zero_run_detector #(
        .RUN_BCKS(ZERO_RUN_BCKS)
    ) u_zero (
        .clk (clk),
        .clr (clr),
        .bck (bck),
        .sdin(sdin),
        .flag(zflag_oe)
    );

    assign adc_out   = dout_q[0];
    assign dac_out   = dout_q[1];
    assign adc_muted = mute_q[0];
    assign dac_muted = mute_q[1];

endmodule

// File: rtl/audio_sync_mute_chk.sv
module audio_sync_mute_chk
    import audio_sync_pkg::*;
#(
    parameter int unsigned DATA_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_dn,
    input logic              bck,
    input logic              sdin,
    input logic [DATA_W-1:0] adc_in,
    input logic [DATA_W-1:0] adc_out,
    input logic [DATA_W-1:0] dac_out,
    input logic              adc_muted,
    input logic              dac_muted,
    input logic              zflag_oe,
    input trk_evt_t          evt
);
    // R2
    adc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        adc_muted |-> adc_out == '0);

    // R2
    dac_zero_chk: assert property (@(posedge clk) disable iff (rst)
        dac_muted |-> dac_out == '0);

    // R2
    adc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !adc_muted |-> adc_out == $past(adc_in));

    // R6
    loss_mute_chk: assert property (@(posedge clk) disable iff (rst)
        evt.loss |=> (adc_muted && dac_muted));

    // R8
    pwr_dn_mute_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> ##1 (adc_muted && dac_muted));

    // R4
    unmute_locked_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_muted) |-> $past(evt.locked));

    // R9
    zflag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(zflag_oe) |-> !$past(sdin, 2));

    // R10
    zflag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bck) && !$past(bck, 2) && $past(sdin)) |=> !zflag_oe);

endmodule

bind audio_sync_mute audio_sync_mute_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_dn   (pwr_dn),
    .bck      (bck),
    .sdin     (sdin),
    .adc_in   (adc_in),
    .adc_out  (adc_out),
    .dac_out  (dac_out),
    .adc_muted(adc_muted),
    .dac_muted(dac_muted),
    .zflag_oe (zflag_oe),
    .evt      (trk_evt)
);

// File: tb/tb_audio_sync_mute.sv
module tb_audio_sync_mute;
    localparam int DW    = 20;
    localparam int FR    = 64;
    localparam int NA    = 9;
    localparam int ND    = 6;
    localparam int RA    = 3;
    localparam int RD    = 2;
    localparam int ZRUN  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_dn = 1'b0;
    logic          bck = 1'b0;
    logic          lrck = 1'b0;
    logic          sdin = 1'b0;
    logic [DW-1:0] adc_in = '0;
    logic [DW-1:0] dac_in = '0;
    logic [DW-1:0] adc_out, dac_out;
    logic          adc_muted, dac_muted, zflag_oe;

    int nchk = 0;
    int nfail = 0;
    int tick = 0;
    logic mid_am, mid_dm;
    logic [DW-1:0] mid_ao, mid_do;

    always #4 clk = ~clk;

    audio_sync_mute #(
        .DATA_W(DW), .FRAME_CLKS(FR), .BCK_CLKS(4), .LOSS_BCKS(6),
        .ADC_PWR_FRAMES(NA), .DAC_PWR_FRAMES(ND),
        .ADC_RESYNC_FRAMES(RA), .DAC_RESYNC_FRAMES(RD),
        .ZERO_RUN_BCKS(ZRUN)
    ) dut (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .bck(bck), .lrck(lrck), .sdin(sdin),
        .adc_in(adc_in), .dac_in(dac_in), .adc_out(adc_out), .dac_out(dac_out),
        .adc_muted(adc_muted), .dac_muted(dac_muted), .zflag_oe(zflag_oe)
    );

    task automatic check(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lrck = 1'b0;
            bck  = (tick % 4) >= 2;
            tick++;
        end
    endtask

    task automatic frame(int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == len / 2) begin
                mid_am = adc_muted;
                mid_dm = dac_muted;
                mid_ao = adc_out;
                mid_do = dac_out;
            end
            lrck = (i < len / 2);
            bck  = (tick % 4) >= 2;
            tick++;
        end
    endtask

    // edge 0 is the first edge of the frame loop; path unmutes from frame 1+n
    task automatic run_release(int na, int nd, string req, int nfr);
        for (int k = 0; k < nfr; k++) begin
            adc_in = DW'(32'h1A000 + k);
            dac_in = DW'(32'h05500 + 3 * k);
            frame(FR);
            check(req, "adc_muted", int'(mid_am), (k < 1 + na) ? 1 : 0);
            check(req, "dac_muted", int'(mid_dm), (k < 1 + nd) ? 1 : 0);
            check({req, " R2"}, "adc_out", int'(mid_ao), (k < 1 + na) ? 0 : int'(adc_in));
            check({req, " R2"}, "dac_out", int'(mid_do), (k < 1 + nd) ? 0 : int'(dac_in));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(5);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bpulse(logic d);
        @(negedge clk);
        bck = 1'b0;
        sdin = d;
        @(negedge clk);
        bck = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int shifts[8];
        shifts = '{20, -20, 24, -24, 25, -25, 28, -28};
        idle(4);
        // R1 reset state
        @(negedge clk);
        check("R1", "adc_muted", int'(adc_muted), 1);
        check("R1", "dac_muted", int'(dac_muted), 1);
        check("R1", "adc_out", int'(adc_out), 0);
        check("R1", "dac_out", int'(dac_out), 0);
        check("R1", "zflag_oe", int'(zflag_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "adc_muted after release", int'(adc_muted), 1);
        check("R1", "dac_out after release", int'(dac_out), 0);

        // R3 R4: release timing from several absolute phases
        foreach (shifts[q]) begin
            if (q < 3) begin
                do_reset();
                idle(q * 13 + (q == 2 ? 11 : 0));
                run_release(NA, ND, "R3 R4", NA + 3);
            end
        end

        // R5 R6 R7: drift sweep around the threshold
        foreach (shifts[s]) begin
            frame(FR + shifts[s]);
            if (shifts[s] <= 24 && shifts[s] >= -24) begin
                for (int j = 0; j < 3; j++) begin
                    frame(FR);
                    check("R5", "adc_muted", int'(mid_am), 0);
                    check("R5", "dac_muted", int'(mid_dm), 0);
                end
            end else begin
                run_release(RA, RD, "R6 R7", RA + 3);
            end
        end

        // R6 absent word clock
        idle(3 * FR);
        run_release(RA, RD, "R6 R7", RA + 3);

        // R8 power-down
        @(negedge clk);
        pwr_dn = 1'b1;
        idle(100);
        check("R8", "adc_muted in power-down", int'(adc_muted), 1);
        check("R8", "dac_muted in power-down", int'(dac_muted), 1);
        check("R8", "adc_out in power-down", int'(adc_out), 0);
        @(negedge clk);
        pwr_dn = 1'b0;
        run_release(NA, ND, "R8", NA + 3);

        // R9 R10 zero run
        bpulse(1'b1);
        check("R10", "zflag_oe after one", int'(zflag_oe), 0);
        for (int n = 1; n <= ZRUN + 6; n++) begin
            bpulse(1'b0);
            check("R9", "zflag_oe", int'(zflag_oe), (n >= ZRUN) ? 1 : 0);
        end
        bpulse(1'b1);
        check("R10", "zflag_oe cleared", int'(zflag_oe), 0);
        for (int n = 1; n <= ZRUN; n++) begin
            bpulse(1'b0);
            if (n >= ZRUN - 1)
                check("R10", "zflag_oe after restart", int'(zflag_oe), (n >= ZRUN) ? 1 : 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule